// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

A bank of up to 32 general-purpose pins controlled through a simple 32-bit register bus with address, write strobe, write data and registered read data. Every pin is set up independently: as a plain input, as a driven output with its output enable raised, or as an interrupt source. An interrupt source can react to a high or low level, to a rising or falling edge, or to both edges.

Pad inputs are brought into the clock domain through a two-stage synchroniser before anything else sees them. Per-pin interrupt status is kept in the block. An enable mask is set with one register and cleared with another, so two software agents can change different bits without read-modify-write. The single interrupt line is raised while any enabled pin has status pending. Software clears latched edges by writing ones to a clear register; level sources simply follow the pin.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pad_oe` is all zero and `irq` is low, so all pins are inputs with interrupts disabled.
- R2: `pad_oe` bit n is 1 only when pin n has mode bit 0 (register 0x00) and direction bit 1 (register 0x04). `pad_out` equals the output data register (0x08), which also reads back the driven value.
- R3: The input data register (0x0C) returns the pad inputs after a two-flop synchroniser.
- R4: A pin with mode bit 1 and edge-select bit 0 (register 0x24) is level sensed: its status bit (0x10) follows the synchronised pin, active high for polarity bit 0 and active low for polarity bit 1 (register 0x20). Writes to the clear register do not change it.
- R5: A pin with mode bit 1 and edge-select bit 1 latches status on a rising edge (polarity 0) or a falling edge (polarity 1). The status stays set until it is cleared.
- R6: With the both-edge bit (register 0x4C) set, an edge-sensed pin latches status on either edge, whatever its polarity bit.
- R7: Writing the clear register (0x14) clears the latched status of each pin whose bit is 1, and leaves pins with a 0 bit unchanged. An edge that arrives in the same cycle as the clear keeps the bit set.
- R8: A write to the disable register (0x18) clears the enable of each pin whose bit is 0 and keeps the others. A write to the enable register (0x1C) sets the enable of each pin whose bit is 1. Reading 0x18 returns 1 for enabled pins.
- R9: `irq` is high exactly while some pin has both status and enable set.
- R10: Pins with mode bit 0 never raise a status bit.
- R11: Register 0x28 is a plain read/write register with no effect on sensing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PINS | Values driven to the pads |
| pad_oe | output | NUM_PINS | Per-pad output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle the assertions check the following: no output enable is raised for an interrupt pin, a level-sensed status tracks the pin from the cycle before, a latched edge survives until it is cleared or beaten by a new edge, an enable write lands as specified, and `irq` never rises with an empty enable mask. The bench scenarios cover the mapping from pad patterns to status across every sensing mode. They also cover the exact cycle in which an edge meets a clear write, the fact that zero bits in clear and disable writes have no effect, and masked status that stays visible to software while `irq` stays low.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  // byte offsets decoded by software
  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_OUT    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_IN     = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_UNMASK = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_POL    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_EDGE   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_FILT   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_BOTH   = 8'h4C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  input  logic int_en,
  input  logic pol,
  input  logic edge_en,
  input  logic both_en,
  input  logic clr_i,
  output logic status_o
);
  logic prev_q, status_q;
  logic act, act_prev, hit, status_d;

  assign act      = sync_i ^ pol;
  assign act_prev = prev_q ^ pol;
  assign hit      = both_en ? (sync_i ^ prev_q) : (act & ~act_prev);

  always_comb begin
    if (!int_en)      status_d = 1'b0;
    else if (edge_en) status_d = hit | (status_q & ~clr_i);
    else              status_d = act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q   <= sync_i;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

  assert_level_follow_R4: assert property (@(posedge clk) disable iff (rst)
    (int_en && !edge_en) |=> (status_q == $past(act)));

  assert_edge_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (int_en && edge_en && status_q && !clr_i) |=> (status_q || !int_en || !edge_en));

  assert_edge_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (int_en && edge_en && hit && clr_i) |=> status_q);

  assert_gpio_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!int_en && !$past(int_en)) |-> !status_q);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);
  localparam int P = NUM_PINS;

  logic [P-1:0] mode_q, dir_q, out_q, pol_q, edge_q, both_q, filt_q, mask_q;
  logic [P-1:0] sync_v, status_v, clr_v, wd, rd_pins;

  assign wd    = bus_wdata[P-1:0];
  assign clr_v = (bus_we && bus_addr == OFS_CLR) ? wd : '0;

  gpio_sync #(.WIDTH(P), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_v)
  );

  for (genvar n = 0; n < P; n++) begin : g_pin
    gpio_pin_sense u_sense (
      .clk(clk), .rst(rst), .sync_i(sync_v[n]),
      .int_en(mode_q[n]), .pol(pol_q[n]), .edge_en(edge_q[n]),
      .both_en(both_q[n]), .clr_i(clr_v[n]), .status_o(status_v[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0; dir_q <= '0; out_q <= '0; pol_q <= '0;
      edge_q <= '0; both_q <= '0; filt_q <= '0; mask_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_MODE:   mode_q <= wd;
        OFS_DIR:    dir_q  <= wd;
        OFS_OUT:    out_q  <= wd;
        OFS_POL:    pol_q  <= wd;
        OFS_EDGE:   edge_q <= wd;
        OFS_BOTH:   both_q <= wd;
        OFS_FILT:   filt_q <= wd;
        OFS_MASK:   mask_q <= mask_q & wd;
        OFS_UNMASK: mask_q <= mask_q | wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_MODE:   rd_pins = mode_q;
      OFS_DIR:    rd_pins = dir_q;
      OFS_OUT:    rd_pins = out_q;
      OFS_IN:     rd_pins = sync_v;
      OFS_STAT:   rd_pins = status_v;
      OFS_MASK:   rd_pins = mask_q;
      OFS_POL:    rd_pins = pol_q;
      OFS_EDGE:   rd_pins = edge_q;
      OFS_BOTH:   rd_pins = both_q;
      OFS_FILT:   rd_pins = filt_q;
      default:    rd_pins = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= BUS_W'(rd_pins);
  end

  assign pad_out = out_q;
  assign pad_oe  = ~mode_q & dir_q;
  assign irq     = |(status_v & mask_q);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && !irq && mask_q == '0));

  assert_oe_gpio_only_R2: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & mode_q) == '0);

  assert_unmask_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_UNMASK) |=> ((mask_q & $past(wd)) == $past(wd)));

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (mask_q != '0));
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  import gpio_bank_pkg::*;
  localparam int NP = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  logic irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(NP)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // fields: mode, pol, edge, both, pad before, pad after, expected status (pins 0..3)
  localparam logic [27:0] VEC [8] = '{
    {4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'h5, 4'h5},  // R4 level high
    {4'hF, 4'hF, 4'h0, 4'h0, 4'hF, 4'h5, 4'hA},  // R4 level low
    {4'hF, 4'h0, 4'hF, 4'h0, 4'h0, 4'h3, 4'h3},  // R5 rising
    {4'hF, 4'hF, 4'hF, 4'h0, 4'hF, 4'h6, 4'h9},  // R5 falling
    {4'hF, 4'h0, 4'hF, 4'hF, 4'h3, 4'h5, 4'h6},  // R6 both edges
    {4'h0, 4'h0, 4'hF, 4'h0, 4'h0, 4'hF, 4'h0},  // R10 gpio mode
    {4'hF, 4'h0, 4'hF, 4'h0, 4'hF, 4'h0, 4'h0},  // R5 falling ignored
    {4'h5, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 4'h5}   // R4 partial mode
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(OFS_MASK, v); chk("R1 mask", v, 0);
    rd(OFS_MODE, v); chk("R1 mode", v, 0);

    for (int i = 0; i < 8; i++) begin
      wr(OFS_MODE, 32'(VEC[i][27:24]));
      wr(OFS_POL,  32'(VEC[i][23:20]));
      wr(OFS_EDGE, 32'(VEC[i][19:16]));
      wr(OFS_BOTH, 32'(VEC[i][15:12]));
      @(negedge clk); pad_in = NP'(VEC[i][11:8]);
      idle(5);
      wr(OFS_CLR, 32'hFFFF_FFFF);
      @(negedge clk); pad_in = NP'(VEC[i][7:4]);
      idle(5);
      rd(OFS_STAT, v);
      chk($sformatf("R4/R5/R6/R10 vector %0d status", i), v, 32'(VEC[i][3:0]));
      chk($sformatf("R9 vector %0d irq masked", i), 32'(irq), 0);
    end

    // R2 / R3
    wr(OFS_MODE, 0); wr(OFS_POL, 0); wr(OFS_EDGE, 0); wr(OFS_BOTH, 0);
    wr(OFS_DIR, 32'h0F); wr(OFS_OUT, 32'h05);
    @(negedge clk);
    chk("R2 oe", 32'(pad_oe), 32'h0F);
    chk("R2 pad_out", 32'(pad_out), 32'h05);
    rd(OFS_OUT, v); chk("R2 out readback", v, 32'h05);
    wr(OFS_MODE, 32'h01);
    @(negedge clk);
    chk("R2 oe interrupt pin", 32'(pad_oe), 32'h0E);
    wr(OFS_MODE, 0); wr(OFS_DIR, 0);
    @(negedge clk); pad_in = 32'hA5C3_0F96;
    idle(3);
    rd(OFS_IN, v); chk("R3 input data", v, 32'hA5C3_0F96);
    pad_in = '0;

    // R11
    wr(OFS_FILT, 32'h1234_5678);
    rd(OFS_FILT, v); chk("R11 filter readback", v, 32'h1234_5678);

    // R8
    wr(OFS_UNMASK, 32'h0F); rd(OFS_MASK, v); chk("R8 unmask", v, 32'h0F);
    wr(OFS_MASK, ~32'h02);  rd(OFS_MASK, v); chk("R8 mask zero bit", v, 32'h0D);
    wr(OFS_MASK, 32'hFFFF_FFFF); rd(OFS_MASK, v); chk("R8 mask ones keep", v, 32'h0D);

    // R9 / R7
    wr(OFS_MASK, 0); wr(OFS_UNMASK, 32'h01);
    wr(OFS_MODE, 32'h03); wr(OFS_EDGE, 32'h03);
    idle(5);
    wr(OFS_CLR, 32'hFFFF_FFFF);
    @(negedge clk); pad_in = 32'h3;
    idle(5);
    chk("R9 irq raised", 32'(irq), 1);
    rd(OFS_STAT, v); chk("R5 status both pins", v, 32'h3);
    wr(OFS_CLR, 0);
    chk("R7 zero clear no effect", 32'(irq), 1);
    wr(OFS_CLR, 32'h1);
    chk("R9 irq after clear", 32'(irq), 0);
    rd(OFS_STAT, v); chk("R9 masked status visible", v, 32'h2);

    // R7 edge in same cycle as clear
    @(negedge clk); pad_in = 32'h2;
    idle(5);
    @(negedge clk); pad_in = 32'h3;
    @(negedge clk);
    @(negedge clk); bus_addr = OFS_CLR; bus_wdata = 32'h1; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(OFS_STAT, v); chk("R7 edge beats clear", v & 32'h1, 32'h1);
    wr(OFS_CLR, 32'h1);
    rd(OFS_STAT, v); chk("R7 clear without edge", v & 32'h1, 0);

    // R4 clear ignored in level mode
    wr(OFS_MODE, 32'h4); wr(OFS_EDGE, 0);
    @(negedge clk); pad_in = 32'h4;
    idle(5);
    wr(OFS_CLR, 32'h4);
    rd(OFS_STAT, v); chk("R4 level ignores clear", v, 32'h4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule